// File: doc/BRIEF.md
# Reversible Gate Primitive Library

This block gathers four bijective combinational primitives for structural use: a 2-wire controlled inverter, a 3-wire controlled exchange, and two 4-wire gates that each combine a selection with an exclusive-OR chain. Every gate has as many outputs as inputs, so its input vector can always be rebuilt from its output vector. One parameterised module provides every gate, and a second parameter picks its forward mapping or its inverse. Because a wire in a reversible netlist may not drive two loads, fan-out is made with the 2-wire gate and its second input tied low.

The top module places each gate in its forward form, feeds the result straight into the matching inverse, and exposes the intermediate and recovered vectors. A separate wrapper configures one 4-wire selection/XOR gate as a one-bit full adder: its third input is held at constant 0, and its first two outputs are carried out on named ports, not left unconnected.

Vectors are packed with the first operand in the most significant bit. The 2-wire gate uses `{a,b}`, the 3-wire gate `{a,b,c}` and the 4-wire gates `{a,b,c,d}`. Outputs follow the same order, `{p,q,r,s}` for the widest gates.

Top module: `revgate_lib_top`

## Requirements
- R1: Copy gate `cnot_fwd` = {a, a^b} for `cnot_in` = {a,b}. With b = 0 the second output equals a, so the gate acts as a fan-out element.
- R2: Exchange gate `cswap_fwd` = {a, a ? c : b, a ? b : c} for `cswap_in` = {a,b,c}. The number of ones in the output equals the number in the input.
- R3: Adder-capable gate: for `tsg_in` = {a,b,c,d}, q = (~a&~c)^~b, r = q^d and s = (q&d)^((a&b)^c). `tsg_fwd` = {a,q,r,s}.
- R4: Mux-XOR gate: for `say_in` = {a,b,c,d}, `say_fwd` = {a, (~a&b)^(a&c), (~a&b)^(a&c)^d, (a&b)^(~a&c)^d}.
- R5: Each forward gate is one-to-one: over all 2^n input vectors, no two inputs give the same output.
- R6: Each inverse output (`*_back`) equals the corresponding gate input for every input vector.
- R7: {`fa_cout`,`fa_sum`} equals the arithmetic sum `fa_a` + `fa_b` + `fa_cin` for all 8 combinations.
- R8: The adder's unused outputs are exposed: `fa_junk_copy` = `fa_a` and `fa_junk_prop` = `fa_a` ^ `fa_b`.
- R9: In every gate, the most significant output bit passes input a through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnot_in | input | 2 | Copy gate inputs {a,b} |
| cnot_fwd | output | 2 | Copy gate outputs {p,q} |
| cnot_back | output | 2 | Copy gate inverse of cnot_fwd |
| cswap_in | input | 3 | Exchange gate inputs {a,b,c} |
| cswap_fwd | output | 3 | Exchange gate outputs {p,q,r} |
| cswap_back | output | 3 | Exchange gate inverse of cswap_fwd |
| tsg_in | input | 4 | Adder-capable gate inputs {a,b,c,d} |
| tsg_fwd | output | 4 | Adder-capable gate outputs {p,q,r,s} |
| tsg_back | output | 4 | Adder-capable gate inverse of tsg_fwd |
| say_in | input | 4 | Mux-XOR gate inputs {a,b,c,d} |
| say_fwd | output | 4 | Mux-XOR gate outputs {p,q,r,s} |
| say_back | output | 4 | Mux-XOR gate inverse of say_fwd |
| fa_a | input | 1 | Adder operand |
| fa_b | input | 1 | Adder operand |
| fa_cin | input | 1 | Adder carry in |
| fa_sum | output | 1 | Adder sum |
| fa_cout | output | 1 | Adder carry out |
| fa_junk_copy | output | 1 | Adder garbage: copy of fa_a |
| fa_junk_prop | output | 1 | Adder garbage: fa_a xor fa_b |

## Verification
Every gate is swept over its whole input space, counting from zero. The sweep drives the low codes, where a = 0 and the pass-through and exchange branches are inactive. It then drives the high codes, where a = 1 turns on the swap in the 3-wire gate and the inverted selection in the 4-wire gates. A record of every output code seen separates a mapping that is merely correct on the tested values from one that is a true permutation. The inverse check separates a forward error from an inverse error. The adder sweep covers all eight carry cases, including both all-zero and all-one operand patterns.

// File: rtl/revgate_pkg.sv
`timescale 1ns/1ps
package revgate_pkg;

  typedef enum logic [1:0] {
    GK_CNOT  = 2'd0,
    GK_CSWAP = 2'd1,
    GK_TSG   = 2'd2,
    GK_SAYEM = 2'd3
  } gate_kind_e;

  function automatic int gate_width(input gate_kind_e k);
    case (k)
      GK_CNOT:  return 2;
      GK_CSWAP: return 3;
      default:  return 4;
    endcase
  endfunction

  // 2-wire controlled inverter; its own inverse
  function automatic logic [1:0] cnot_map(input logic [1:0] v);
    logic a, b;
    {a, b} = v;
    return {a, a ^ b};
  endfunction

  // 3-wire controlled exchange; its own inverse
  function automatic logic [2:0] cswap_map(input logic [2:0] v);
    logic a, b, c;
    {a, b, c} = v;
    return {a, (~a & b) ^ (a & c), (~a & c) ^ (a & b)};
  endfunction

  function automatic logic [3:0] tsg_map(input logic [3:0] v);
    logic a, b, c, d, q;
    {a, b, c, d} = v;
    q = (~a & ~c) ^ ~b;
    return {a, q, q ^ d, (q & d) ^ ((a & b) ^ c)};
  endfunction

  function automatic logic [3:0] tsg_unmap(input logic [3:0] w);
    logic p, q, r, s, d, t, b, c;
    {p, q, r, s} = w;
    d = q ^ r;
    t = s ^ (q & d);
    if (p) begin
      b = ~q;
      c = t ^ b;
    end else begin
      c = t;
      b = q ^ t;
    end
    return {p, b, c, d};
  endfunction

  function automatic logic [3:0] sayem_map(input logic [3:0] v);
    logic a, b, c, d, q;
    {a, b, c, d} = v;
    q = (~a & b) ^ (a & c);
    return {a, q, q ^ d, (a & b) ^ (~a & c) ^ d};
  endfunction

  function automatic logic [3:0] sayem_unmap(input logic [3:0] w);
    logic p, q, r, s, d, u;
    {p, q, r, s} = w;
    d = q ^ r;
    u = s ^ d;
    return {p, p ? u : q, p ? q : u, d};
  endfunction

endpackage

// File: rtl/rev_gate.sv
`timescale 1ns/1ps
module rev_gate
  import revgate_pkg::*;
#(
  parameter gate_kind_e KIND    = GK_CNOT,
  parameter bit         INVERSE = 1'b0,
  localparam int        W       = gate_width(KIND)
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);

  generate
    if (KIND == GK_CNOT) begin : g_cnot
      assign y = cnot_map(x);
    end else if (KIND == GK_CSWAP) begin : g_cswap
      assign y = cswap_map(x);
    end else if (KIND == GK_TSG) begin : g_tsg
      if (INVERSE) begin : g_inv
        assign y = tsg_unmap(x);
      end else begin : g_fwd
        assign y = tsg_map(x);
      end
    end else begin : g_sayem
      if (INVERSE) begin : g_inv
        assign y = sayem_unmap(x);
      end else begin : g_fwd
        assign y = sayem_map(x);
      end
    end
  endgenerate

endmodule

// File: rtl/rev_full_adder.sv
`timescale 1ns/1ps
module rev_full_adder
  import revgate_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic sum,
  output logic cout,
  output logic junk_copy,
  output logic junk_prop
);

  localparam logic TIE_C = 1'b0;  // constant input fixing the adder mode

  logic [3:0] gate_in;
  logic [3:0] gate_out;

  assign gate_in = {a, b, TIE_C, cin};

  rev_gate #(.KIND(GK_TSG), .INVERSE(1'b0)) i_tsg (
    .x (gate_in),
    .y (gate_out)
  );

  assign junk_copy = gate_out[3];
  assign junk_prop = gate_out[2];
  assign sum       = gate_out[1];
  assign cout      = gate_out[0];

endmodule

// File: rtl/revgate_lib_top.sv
`timescale 1ns/1ps
module revgate_lib_top
  import revgate_pkg::*;
(
  input  logic [1:0] cnot_in,
  output logic [1:0] cnot_fwd,
  output logic [1:0] cnot_back,
  input  logic [2:0] cswap_in,
  output logic [2:0] cswap_fwd,
  output logic [2:0] cswap_back,
  input  logic [3:0] tsg_in,
  output logic [3:0] tsg_fwd,
  output logic [3:0] tsg_back,
  input  logic [3:0] say_in,
  output logic [3:0] say_fwd,
  output logic [3:0] say_back,
  input  logic       fa_a,
  input  logic       fa_b,
  input  logic       fa_cin,
  output logic       fa_sum,
  output logic       fa_cout,
  output logic       fa_junk_copy,
  output logic       fa_junk_prop
);

  rev_gate #(.KIND(GK_CNOT),  .INVERSE(1'b0)) i_cnot_f  (.x(cnot_in),   .y(cnot_fwd));
  rev_gate #(.KIND(GK_CNOT),  .INVERSE(1'b1)) i_cnot_b  (.x(cnot_fwd),  .y(cnot_back));
  rev_gate #(.KIND(GK_CSWAP), .INVERSE(1'b0)) i_cswap_f (.x(cswap_in),  .y(cswap_fwd));
  rev_gate #(.KIND(GK_CSWAP), .INVERSE(1'b1)) i_cswap_b (.x(cswap_fwd), .y(cswap_back));
  rev_gate #(.KIND(GK_TSG),   .INVERSE(1'b0)) i_tsg_f   (.x(tsg_in),    .y(tsg_fwd));
  rev_gate #(.KIND(GK_TSG),   .INVERSE(1'b1)) i_tsg_b   (.x(tsg_fwd),   .y(tsg_back));
  rev_gate #(.KIND(GK_SAYEM), .INVERSE(1'b0)) i_say_f   (.x(say_in),    .y(say_fwd));
  rev_gate #(.KIND(GK_SAYEM), .INVERSE(1'b1)) i_say_b   (.x(say_fwd),   .y(say_back));

  rev_full_adder i_fa (
    .a         (fa_a),
    .b         (fa_b),
    .cin       (fa_cin),
    .sum       (fa_sum),
    .cout      (fa_cout),
    .junk_copy (fa_junk_copy),
    .junk_prop (fa_junk_prop)
  );

endmodule

// File: rtl/revgate_lib_chk.sv
`timescale 1ns/1ps
module revgate_lib_chk (
  input logic [1:0] cnot_in,
  input logic [1:0] cnot_fwd,
  input logic [1:0] cnot_back,
  input logic [2:0] cswap_in,
  input logic [2:0] cswap_fwd,
  input logic [2:0] cswap_back,
  input logic [3:0] tsg_in,
  input logic [3:0] tsg_fwd,
  input logic [3:0] tsg_back,
  input logic [3:0] say_in,
  input logic [3:0] say_fwd,
  input logic [3:0] say_back,
  input logic       fa_a,
  input logic       fa_b,
  input logic       fa_cin,
  input logic       fa_sum,
  input logic       fa_cout,
  input logic       fa_junk_copy,
  input logic       fa_junk_prop
);

  always_comb begin
    if (!$isunknown({cnot_in, cswap_in, tsg_in, say_in})) begin
      p_roundtrip_r6: assert ({cnot_back, cswap_back, tsg_back, say_back}
                              == {cnot_in, cswap_in, tsg_in, say_in})
        else $error("inverse chain does not restore inputs");
      p_passthru_r9: assert ({cnot_fwd[1], cswap_fwd[2], tsg_fwd[3], say_fwd[3]}
                             == {cnot_in[1], cswap_in[2], tsg_in[3], say_in[3]})
        else $error("control wire altered");
      p_ones_kept_r2: assert ($countones(cswap_fwd) == $countones(cswap_in))
        else $error("exchange gate changed weight");
    end
    if (!$isunknown({fa_a, fa_b, fa_cin})) begin
      p_adder_sum_r7: assert ({1'b0, fa_cout, fa_sum}
                              == 3'(fa_a) + 3'(fa_b) + 3'(fa_cin))
        else $error("adder result wrong");
      p_junk_ports_r8: assert ({fa_junk_copy, fa_junk_prop} == {fa_a, fa_a ^ fa_b})
        else $error("adder garbage wrong");
    end
  end

endmodule

bind revgate_lib_top revgate_lib_chk i_revgate_lib_chk (
  .cnot_in      (cnot_in),
  .cnot_fwd     (cnot_fwd),
  .cnot_back    (cnot_back),
  .cswap_in     (cswap_in),
  .cswap_fwd    (cswap_fwd),
  .cswap_back   (cswap_back),
  .tsg_in       (tsg_in),
  .tsg_fwd      (tsg_fwd),
  .tsg_back     (tsg_back),
  .say_in       (say_in),
  .say_fwd      (say_fwd),
  .say_back     (say_back),
  .fa_a         (fa_a),
  .fa_b         (fa_b),
  .fa_cin       (fa_cin),
  .fa_sum       (fa_sum),
  .fa_cout      (fa_cout),
  .fa_junk_copy (fa_junk_copy),
  .fa_junk_prop (fa_junk_prop)
);

// File: tb/test_revgate_lib_top.sv
`timescale 1ns/1ps
module test_revgate_lib_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [1:0] cnot_in = '0, cnot_fwd, cnot_back;
  logic [2:0] cswap_in = '0, cswap_fwd, cswap_back;
  logic [3:0] tsg_in = '0, tsg_fwd, tsg_back;
  logic [3:0] say_in = '0, say_fwd, say_back;
  logic fa_a = 1'b0, fa_b = 1'b0, fa_cin = 1'b0;
  logic fa_sum, fa_cout, fa_junk_copy, fa_junk_prop;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  revgate_lib_top i_revgate_lib_top (
    .cnot_in(cnot_in), .cnot_fwd(cnot_fwd), .cnot_back(cnot_back),
    .cswap_in(cswap_in), .cswap_fwd(cswap_fwd), .cswap_back(cswap_back),
    .tsg_in(tsg_in), .tsg_fwd(tsg_fwd), .tsg_back(tsg_back),
    .say_in(say_in), .say_fwd(say_fwd), .say_back(say_back),
    .fa_a(fa_a), .fa_b(fa_b), .fa_cin(fa_cin),
    .fa_sum(fa_sum), .fa_cout(fa_cout),
    .fa_junk_copy(fa_junk_copy), .fa_junk_prop(fa_junk_prop)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bitof(input int v, input int pos);
    return (v >> pos) % 2;
  endfunction

  bit [3:0]  seen_cnot;
  bit [7:0]  seen_cswap;
  bit [15:0] seen_tsg, seen_say;

  initial begin
    int a, b, c, d, q, r, s, m;
    seen_cnot = '0; seen_cswap = '0; seen_tsg = '0; seen_say = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // all-zero start: R1 and R7 baseline
    chk("R1 zero input", int'(cnot_fwd), 0);
    chk("R7 zero input", int'({fa_cout, fa_sum}), 0);

    for (int v = 0; v < 16; v++) begin
      @(posedge clk);
      cnot_in  = 2'(v);
      cswap_in = 3'(v);
      tsg_in   = 4'(v);
      say_in   = 4'(v);
      {fa_a, fa_b, fa_cin} = 3'(v);
      @(negedge clk);
      a = bitof(v, 3); b = bitof(v, 2); c = bitof(v, 1); d = bitof(v, 0);

      if (v < 4) begin
        // R1: copy gate, {a,b} = bits [1:0]
        chk("R1 cnot", int'(cnot_fwd), bitof(v,1)*2 + (bitof(v,1)+bitof(v,0))%2);
        if (bitof(v,0) == 0) chk("R1 fan-out copy", int'(cnot_fwd[0]), bitof(v,1));
        chk("R6 cnot inverse", int'(cnot_back), v);
        chk("R9 cnot pass", int'(cnot_fwd[1]), bitof(v,1));
        seen_cnot[cnot_fwd] = 1'b1;
      end
      if (v < 8) begin
        // R2: exchange gate, {a,b,c} = bits [2:0]
        m = (bitof(v,2) == 1) ? (4 + bitof(v,0)*2 + bitof(v,1)) : v;
        chk("R2 cswap", int'(cswap_fwd), m);
        chk("R2 weight", $countones(cswap_fwd), bitof(v,0)+bitof(v,1)+bitof(v,2));
        chk("R6 cswap inverse", int'(cswap_back), v);
        chk("R9 cswap pass", int'(cswap_fwd[2]), bitof(v,2));
        seen_cswap[cswap_fwd] = 1'b1;
        // R7 / R8: adder with {a,b,cin} = bits [2:0]
        chk("R7 adder", int'({fa_cout, fa_sum}), bitof(v,2)+bitof(v,1)+bitof(v,0));
        chk("R8 junk copy", int'(fa_junk_copy), bitof(v,2));
        chk("R8 junk prop", int'(fa_junk_prop), (bitof(v,2)+bitof(v,1))%2);
      end
      // R3: adder-capable gate
      q = ((a == 0 && c == 0) ? 1 : 0) ^ (1 - b);
      r = q ^ d;
      s = (q * d) ^ ((a * b) ^ c);
      chk("R3 tsg", int'(tsg_fwd), a*8 + q*4 + r*2 + s);
      chk("R6 tsg inverse", int'(tsg_back), v);
      chk("R9 tsg pass", int'(tsg_fwd[3]), a);
      seen_tsg[tsg_fwd] = 1'b1;
      // R4: mux-XOR gate
      q = (a == 1) ? c : b;
      r = q ^ d;
      s = ((a == 1) ? b : c) ^ d;
      chk("R4 sayem", int'(say_fwd), a*8 + q*4 + r*2 + s);
      chk("R6 sayem inverse", int'(say_back), v);
      chk("R9 sayem pass", int'(say_fwd[3]), a);
      seen_say[say_fwd] = 1'b1;
    end

    // R5: every output code reached once means no collisions
    chk("R5 cnot one-to-one", $countones(seen_cnot), 4);
    chk("R5 cswap one-to-one", $countones(seen_cswap), 8);
    chk("R5 tsg one-to-one", $countones(seen_tsg), 16);
    chk("R5 sayem one-to-one", $countones(seen_say), 16);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule